// File: doc/BRIEF.md
# Isochronous Transaction Slot Executor

This block runs one micro-frame slot of a high-speed isochronous descriptor that has already been fetched. The descriptor carries eight transaction records, one for each micro-frame of a frame. It also carries a small array of buffer page pointers and the endpoint fields: device address, endpoint number, direction and maximum packet size. A `start` pulse makes the block pick the record named by the low three bits of the frame index. If that record is active, the block raises a bus request with the buffer start address, the token fields, the direction and the byte count. If it is not active, the block reports a skip.

When the bus engine finishes, it returns the number of bytes moved and three error flags. The block then presents the updated record for write-back for exactly one cycle. While `busy` is high, the descriptor inputs must be held stable.

Record layout, LSB first: bits [11:0] are the buffer offset, [14:12] the page select, [26:15] the transaction length, [27] transaction error, [28] babble, [29] buffer error and [30] Active. Record n occupies `desc_recs[n*31 +: 31]` and page pointer k occupies `desc_pages[k*20 +: 20]`. The buffer address is `{page pointer, offset}`.

Top module: `iso_slot_exec`

## Requirements
- R1: After reset, `busy`, `bus_req`, `wb_valid` and `wb_skip` are all low.
- R2: The record used is the one at index `frame_idx[2:0]` (for example 3'b010 selects record 2), and `wb_idx` reports that index.
- R3: If the selected record has Active (bit 30) clear, no bus request is made. In the cycle after `start`, `wb_valid` and `wb_skip` are high and `wb_rec` equals the record unchanged.
- R4: If Active is set, `bus_req` rises in the cycle after `start` and stays high until `bus_done` is sampled. `bus_addr` is the page pointer chosen by bits [14:12], joined above the 12-bit offset. A page select of 7 (beyond the seven pointers) gives an all-zero page part.
- R5: While requesting, `bus_dev`, `bus_ep` and `bus_dir_in` equal `ep_dev`, `ep_num` and `ep_dir_in`.
- R6: `bus_len` is the smaller of the record's transaction length and `ep_mps`.
- R7: In the written-back record, the length is the old length minus `bus_bytes`, floored at zero. Offset and page select are unchanged.
- R8: In the written-back record, Active is cleared, and each error bit is its old value ORed with the matching bus error input (`bus_err_buf`, `bus_err_babble`, `bus_err_xact`).
- R9: After `bus_done`, `wb_valid` is high for exactly one cycle with `wb_skip` low, and `busy` then drops.
- R10: `start` is ignored while `busy` is high, and `bus_done` is ignored when no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run the slot for the current frame index |
| frame_idx | input | 14 | Frame index; bits [2:0] pick the record |
| desc_recs | input | 248 | Eight 31-bit transaction records |
| desc_pages | input | 140 | Seven 20-bit buffer page pointers |
| ep_dev | input | 7 | Endpoint device address |
| ep_num | input | 4 | Endpoint number |
| ep_dir_in | input | 1 | Direction, 1 = IN |
| ep_mps | input | 11 | Maximum packet size in bytes |
| busy | output | 1 | Slot in progress |
| bus_req | output | 1 | Transaction request to the bus engine |
| bus_addr | output | 32 | Buffer start address |
| bus_dev | output | 7 | Token device address |
| bus_ep | output | 4 | Token endpoint number |
| bus_dir_in | output | 1 | Transfer direction |
| bus_len | output | 12 | Byte count for the transaction |
| bus_done | input | 1 | Bus engine finished |
| bus_bytes | input | 12 | Bytes actually moved |
| bus_err_buf | input | 1 | Buffer overrun or underrun |
| bus_err_babble | input | 1 | Babble detected |
| bus_err_xact | input | 1 | Transaction error |
| wb_valid | output | 1 | Updated record valid for write-back |
| wb_skip | output | 1 | Slot skipped, record inactive |
| wb_idx | output | 3 | Index of the written-back record |
| wb_rec | output | 31 | Updated record |

## Verification
The bench targets a different record index with each vector. It surrounds the target with distinct filler records, so that selecting the wrong record or reading the wrong page shows up at once in the address and in the written-back record.

The length cases are chosen to tell each path apart:
- a length below the maximum packet size;
- a length above it;
- a zero maximum packet size;
- more bytes moved than requested, which must floor at zero.

Error inputs are driven both on clean records and on records whose error bits are already set, which separates the OR of old and new bits from a plain overwrite. Inactive records with stale error bits confirm that a skip leaves the record untouched. Two further directed cases check that a late `start` and a stray `bus_done` are ignored.

// File: rtl/iso_slot_exec.sv
module iso_slot_exec #(
  parameter int FIDX_W  = 14,
  parameter int PAGE_W  = 20,
  parameter int NPAGE   = 7,
  parameter int MPS_W   = 11,
  parameter int OFF_W   = 12,
  parameter int LEN_W   = 12,
  parameter int PGSEL_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [FIDX_W-1:0]              frame_idx,
  input  logic [8*(OFF_W+PGSEL_W+LEN_W+4)-1:0] desc_recs,
  input  logic [NPAGE*PAGE_W-1:0]        desc_pages,
  input  logic [6:0]                     ep_dev,
  input  logic [3:0]                     ep_num,
  input  logic                           ep_dir_in,
  input  logic [MPS_W-1:0]               ep_mps,
  output logic                           busy,
  output logic                           bus_req,
  output logic [PAGE_W+OFF_W-1:0]        bus_addr,
  output logic [6:0]                     bus_dev,
  output logic [3:0]                     bus_ep,
  output logic                           bus_dir_in,
  output logic [LEN_W-1:0]               bus_len,
  input  logic                           bus_done,
  input  logic [LEN_W-1:0]               bus_bytes,
  input  logic                           bus_err_buf,
  input  logic                           bus_err_babble,
  input  logic                           bus_err_xact,
  output logic                           wb_valid,
  output logic                           wb_skip,
  output logic [2:0]                     wb_idx,
  output logic [OFF_W+PGSEL_W+LEN_W+3:0] wb_rec
);
  localparam int IDX_W  = 3;
  localparam int REC_W  = OFF_W + PGSEL_W + LEN_W + 4;
  localparam int PG_LO  = OFF_W;
  localparam int LEN_LO = OFF_W + PGSEL_W;
  localparam int XERR   = LEN_LO + LEN_W;
  localparam int BAB    = XERR + 1;
  localparam int BERR   = XERR + 2;
  localparam int ACT    = XERR + 3;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_WB} state_t;
  state_t state;

  logic [REC_W-1:0]   rec_q, rec_sel, rec_upd;
  logic [IDX_W-1:0]   idx_q;
  logic               skip_q;
  logic [PAGE_W-1:0]  page_ptr;
  logic [LEN_W-1:0]   cur_len, mps_ext, len_left;
  logic [PGSEL_W-1:0] cur_pg;

  assign rec_sel = desc_recs[frame_idx[IDX_W-1:0]*REC_W +: REC_W];
  assign cur_len = rec_q[LEN_LO +: LEN_W];
  assign cur_pg  = rec_q[PG_LO +: PGSEL_W];
  assign mps_ext = LEN_W'(ep_mps);

  always_comb begin
    page_ptr = '0;
    for (int k = 0; k < NPAGE; k++)
      if (cur_pg == PGSEL_W'(k)) page_ptr = desc_pages[k*PAGE_W +: PAGE_W];
  end

  assign len_left = (cur_len >= bus_bytes) ? cur_len - bus_bytes : '0;

  always_comb begin
    rec_upd = rec_q;
    rec_upd[LEN_LO +: LEN_W] = len_left;
    rec_upd[ACT]  = 1'b0;
    rec_upd[BERR] = rec_q[BERR] | bus_err_buf;
    rec_upd[BAB]  = rec_q[BAB]  | bus_err_babble;
    rec_upd[XERR] = rec_q[XERR] | bus_err_xact;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rec_q  <= '0;
      idx_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx_q  <= frame_idx[IDX_W-1:0];
          rec_q  <= rec_sel;
          skip_q <= !rec_sel[ACT];
          state  <= rec_sel[ACT] ? S_BUS : S_WB;
        end
        S_BUS: if (bus_done) begin
          rec_q <= rec_upd;
          state <= S_WB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign bus_req    = (state == S_BUS);
  assign bus_addr   = {page_ptr, rec_q[OFF_W-1:0]};
  assign bus_dev    = ep_dev;
  assign bus_ep     = ep_num;
  assign bus_dir_in = ep_dir_in;
  assign bus_len    = (cur_len < mps_ext) ? cur_len : mps_ext;
  assign wb_valid   = (state == S_WB);
  assign wb_skip    = wb_valid & skip_q;
  assign wb_idx     = idx_q;
  assign wb_rec     = rec_q;
endmodule

// File: rtl/iso_slot_exec_chk.sv
module iso_slot_exec_chk #(
  parameter int MPS_W = 11,
  parameter int LEN_W = 12,
  parameter int REC_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             bus_req,
  input logic             bus_done,
  input logic [LEN_W-1:0] bus_len,
  input logic [MPS_W-1:0] ep_mps,
  input logic             wb_valid,
  input logic             wb_skip,
  input logic [2:0]       wb_idx,
  input logic [REC_W-1:0] wb_rec
);
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req);
  a_r9_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done |=> wb_valid && !wb_skip);
  a_r9_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid && !busy);
  a_r8_active_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_skip |-> !wb_rec[REC_W-1]);
  a_r3_skip_direct: assert property (@(posedge clk) disable iff (!rst_n)
    wb_skip |-> !$past(busy));
  a_r6_len_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_len <= LEN_W'(ep_mps));
  a_r10_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wb_idx));
endmodule

bind iso_slot_exec iso_slot_exec_chk #(.MPS_W(MPS_W), .LEN_W(LEN_W), .REC_W(REC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_req(bus_req), .bus_done(bus_done),
  .bus_len(bus_len), .ep_mps(ep_mps), .wb_valid(wb_valid), .wb_skip(wb_skip),
  .wb_idx(wb_idx), .wb_rec(wb_rec)
);

// File: tb/iso_slot_exec_tb_top.sv
module iso_slot_exec_tb_top;
  localparam int REC_W = 31;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic start = 0, ep_dir_in = 0, bus_done = 0;
  logic bus_err_buf = 0, bus_err_babble = 0, bus_err_xact = 0;
  logic [13:0] frame_idx = '0;
  logic [8*REC_W-1:0] desc_recs = '0;
  logic [139:0] desc_pages = '0;
  logic [6:0] ep_dev = '0;
  logic [3:0] ep_num = '0;
  logic [10:0] ep_mps = '0;
  logic [11:0] bus_bytes = '0;
  logic busy, bus_req, bus_dir_in, wb_valid, wb_skip;
  logic [31:0] bus_addr;
  logic [6:0] bus_dev;
  logic [3:0] bus_ep;
  logic [11:0] bus_len;
  logic [2:0] wb_idx;
  logic [REC_W-1:0] wb_rec;

  iso_slot_exec dut_i (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [13:0] fidx;
    logic [2:0]  pg;
    logic [11:0] off;
    logic [11:0] len;
    logic        act;
    logic [10:0] mps;
    logic [11:0] bytes;
    logic [2:0]  nerr;   // {buf, babble, xact} from bus
    logic [2:0]  oerr;   // {buf, babble, xact} already in record
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{14'h0002, 3'd1, 12'h123, 12'h300, 1'b1, 11'h400, 12'h300, 3'b000, 3'b000},
    '{14'h3FFD, 3'd6, 12'hFFF, 12'h800, 1'b1, 11'h200, 12'h200, 3'b010, 3'b000},
    '{14'h0007, 3'd7, 12'h040, 12'h010, 1'b1, 11'h400, 12'h010, 3'b101, 3'b000},
    '{14'h0008, 3'd2, 12'h555, 12'h100, 1'b0, 11'h400, 12'h000, 3'b000, 3'b000},
    '{14'h1233, 3'd0, 12'h00A, 12'h005, 1'b1, 11'h7FF, 12'h009, 3'b000, 3'b001},
    '{14'h0CC4, 3'd3, 12'h777, 12'h020, 1'b0, 11'h100, 12'h000, 3'b000, 3'b111},
    '{14'h2AAE, 3'd5, 12'h3C0, 12'h0C8, 1'b1, 11'h000, 12'h000, 3'b000, 3'b100},
    '{14'h0001, 3'd4, 12'h800, 12'h400, 1'b1, 11'h3FF, 12'h3FF, 3'b011, 3'b010}
  };

  function automatic logic [REC_W-1:0] mkrec(input logic a, input logic [2:0] e,
      input logic [11:0] l, input logic [2:0] p, input logic [11:0] o);
    return {a, e, l, p, o};
  endfunction

  function automatic logic [19:0] page_of(input int k);
    return 20'hA0000 + 20'(k * 20'h01111);
  endfunction

  task automatic load(input vec_t v, input int i);
    for (int k = 0; k < 8; k++)
      desc_recs[k*REC_W +: REC_W] = 31'h1234567 ^ 31'(k * 32'h01010101);
    desc_recs[v.fidx[2:0]*REC_W +: REC_W] = mkrec(v.act, v.oerr, v.len, v.pg, v.off);
    frame_idx = v.fidx;
    ep_mps = v.mps;
    ep_dev = 7'(7'h10 + i);
    ep_num = 4'(i);
    ep_dir_in = i[0];
  endtask

  initial begin
    for (int k = 0; k < 7; k++) desc_pages[k*20 +: 20] = page_of(k);
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 bus_req", bus_req, 0);
    chk("R1 wb_valid", wb_valid, 0); chk("R1 wb_skip", wb_skip, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [REC_W-1:0] orig, exp_rec;
      logic [11:0] exp_len;
      load(v, i);
      orig = mkrec(v.act, v.oerr, v.len, v.pg, v.off);
      start = 1; @(negedge clk); start = 0;
      if (!v.act) begin
        chk("R3 no req", bus_req, 0);
        chk("R3 skip", {wb_valid, wb_skip}, 2'b11);
        chk("R3 unchanged", wb_rec, orig);
        chk("R2 idx", wb_idx, v.fidx[2:0]);
      end else begin
        chk("R4 req", bus_req, 1);
        chk("R4 addr", bus_addr, {(v.pg < 7) ? page_of(int'(v.pg)) : 20'h0, v.off});
        chk("R5 token", {bus_dev, bus_ep, bus_dir_in}, {7'(7'h10 + i), 4'(i), i[0]});
        chk("R6 len", bus_len, (v.len < {1'b0, v.mps}) ? v.len : {1'b0, v.mps});
        @(negedge clk);
        chk("R4 held", bus_req, 1);
        bus_bytes = v.bytes;
        {bus_err_buf, bus_err_babble, bus_err_xact} = v.nerr;
        bus_done = 1; @(negedge clk); bus_done = 0;
        {bus_err_buf, bus_err_babble, bus_err_xact} = 3'b000;
        exp_len = (v.bytes > v.len) ? 12'h0 : v.len - v.bytes;
        exp_rec = mkrec(1'b0, v.oerr | v.nerr, exp_len, v.pg, v.off);
        chk("R9 wb", {wb_valid, wb_skip, bus_req}, 3'b100);
        chk("R7 R8 rec", wb_rec, exp_rec);
        chk("R2 idx", wb_idx, v.fidx[2:0]);
      end
      @(negedge clk);
      chk("R9 one cycle", {wb_valid, busy}, 2'b00);
      @(negedge clk);
    end

    // R10: start while busy ignored
    load(VECS[0], 0);
    start = 1; @(negedge clk); start = 0;
    frame_idx = 14'h0005;
    desc_recs[5*REC_W +: REC_W] = mkrec(1'b0, 3'b000, 12'h1, 3'd0, 12'h0);
    start = 1; @(negedge clk); start = 0;
    chk("R10 start ignored", {bus_req, wb_valid, wb_idx}, {2'b10, 3'd2});
    bus_bytes = 12'h100; bus_done = 1; @(negedge clk); bus_done = 0;
    chk("R10 wb idx", {wb_valid, wb_idx}, {1'b1, 3'd2});
    @(negedge clk);
    chk("R10 no second slot", {busy, wb_valid}, 2'b00);

    // R10: stray bus_done ignored
    bus_done = 1; @(negedge clk); bus_done = 0;
    chk("R10 stray done", {busy, wb_valid, bus_req}, 3'b000);
    @(negedge clk);
    chk("R10 stray done later", {busy, wb_valid}, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule